// File: doc/BRIEF.md
# Bidirectional GPIO Port Pair with Halt Wake-Up

This block provides two general-purpose I/O ports behind a small CPU register bus. Port A is eight pins wide and port B is three pins wide. Each port has an output latch and a direction register, and every pin has its own direction bit. Software writes the latch and the direction through the bus. A read of a data register gives the live pad level on input pins and the latch on output pins, so read-modify-write bit operations keep the output values intact.

The pad drivers sit outside the block and see three vectors per port: the pad input, the output value and the output enable. A per-port pull-up option input, ANDed with the direction bits, produces per-pin pull-up requests. While the core is halted, a falling edge on a port A input pin that has its wake-up option set raises a one-cycle wake pulse. The pad is first passed through a two-flop synchronizer.

Top module: `gpio_wake_port`

## Requirements
- R1: The registers sit at these bus addresses: 12h is port A data, 13h is port A direction, 14h is port B data and 15h is port B direction. Any other address reads as 00h, and a write to it changes no register.
- R2: While `rst_n` is low, the data and direction registers of both ports are set to all ones. After reset, port A direction reads FFh, port B direction reads 07h, every `*_oe` bit is 0 and every `*_out` bit is 1.
- R3: A direction bit of 1 makes the pin an input, with its `*_oe` bit at 0. A direction bit of 0 drives the output latch onto `*_out`, with its `*_oe` bit at 1.
- R4: A data register read returns the pad level in bits whose direction bit is 1, and the output latch in bits whose direction bit is 0.
- R5: An output latch changes only when its data register is written. A write while the pin is an input still updates the latch, and the new value shows once the pin is switched to output.
- R6: Bits 7..3 of both port B registers read as 0, and writing them has no effect.
- R7: A pulse on `warm_rst` leaves every data and direction register unchanged.
- R8: Wake-up needs three conditions: `halt` is high, port A bit i has `wake_en_a[i]`=1, and that bit's direction bit is 1. When a falling edge on `pa_in[i]` meets them, `wake` is high for exactly one cycle. The pulse appears after the third rising clock edge following the pad change.
- R9: `wake` stays low in each of these cases: `halt` is low, the bit's wake-up option is 0, the bit is an output, or the edge is rising.
- R10: `pa_pu[i]` equals `pu_opt_a` AND the port A direction bit i. `pb_pu` is formed the same way from `pu_opt_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on, external, watchdog while running) |
| warm_rst | input | 1 | Warm reset from a watchdog time-out while halted |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pa_in | input | 8 | Port A pad levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pa_pu | output | 8 | Port A pull-up requests |
| pb_in | input | 3 | Port B pad levels |
| pb_out | output | 3 | Port B output values |
| pb_oe | output | 3 | Port B output enables |
| pb_pu | output | 3 | Port B pull-up requests |
| pu_opt_a | input | 1 | Port A pull-up option |
| pu_opt_b | input | 1 | Port B pull-up option |
| wake_en_a | input | 8 | Per-bit port A wake-up option |
| halt | input | 1 | Core is in low-power halt |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
The hardest case to reach is the wake-up path. It needs a falling edge on a pin that is enabled and set as input while halt is high, and the pin must already have sat high long enough to fill the synchronizer. The stimulus first parks every pin high for several cycles and only then raises halt. It then drops one pin at a time and checks `wake` on each of the next five cycles, expecting it high on exactly the third. The same window is replayed with one condition broken each time: halt low, option clear, pin set as output, and a rising edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_MAX_W = 8;
  typedef logic [PORT_MAX_W-1:0] port_word_t;

  // Input bits (dir=1) show the pad, output bits (dir=0) show the latch.
  function automatic port_word_t pick_readback(input port_word_t latch,
                                               input port_word_t dir,
                                               input port_word_t pad);
    return (pad & dir) | (latch & ~dir);
  endfunction
endpackage

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_data
);
  import gpio_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '1;
    end else begin
      if (wr_data) latch_q <= wdata;
      if (wr_dir)  dir_q   <= wdata;
    end
  end

  assign rd_data = W'(pick_readback(port_word_t'(latch_q), port_word_t'(dir_q),
                                    port_word_t'(pad_in)));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(latch_q));
  assert_latch_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> latch_q == $past(wdata));
endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm_rst,
  input  logic         halt,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] wake_en,
  input  logic [W-1:0] in_mode,
  output logic         wake
);
  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic [W-1:0] fell, wake_hits;
  logic         wake_d;

  assign fell      = prev_q & ~sync2_q;
  assign wake_hits = fell & wake_en & in_mode;
  assign wake_d    = halt & (|wake_hits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
      prev_q  <= '1;
      wake    <= 1'b0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (warm_rst) begin
        prev_q <= '0;
        wake   <= 1'b0;
      end else begin
        prev_q <= sync2_q;
        wake   <= wake_d;
      end
    end
  end

  assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  assert_wake_in_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(halt));
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter int          PA_W       = 8,
  parameter int          PB_W       = 3,
  parameter logic [7:0]  PA_DATA_AD = 8'h12,
  parameter logic [7:0]  PA_DIR_AD  = 8'h13,
  parameter logic [7:0]  PB_DATA_AD = 8'h14,
  parameter logic [7:0]  PB_DIR_AD  = 8'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PA_W-1:0]   pa_in,
  output logic [PA_W-1:0]   pa_out,
  output logic [PA_W-1:0]   pa_oe,
  output logic [PA_W-1:0]   pa_pu,
  input  logic [PB_W-1:0]   pb_in,
  output logic [PB_W-1:0]   pb_out,
  output logic [PB_W-1:0]   pb_oe,
  output logic [PB_W-1:0]   pb_pu,
  input  logic              pu_opt_a,
  input  logic              pu_opt_b,
  input  logic [PA_W-1:0]   wake_en_a,
  input  logic              halt,
  output logic              wake
);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(PA_DATA_AD);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(PA_DIR_AD);
  localparam logic [ADDR_W-1:0] B_DAT = ADDR_W'(PB_DATA_AD);
  localparam logic [ADDR_W-1:0] B_DIR = ADDR_W'(PB_DIR_AD);

  logic [PA_W-1:0] a_latch, a_dir, a_rd;
  logic [PB_W-1:0] b_latch, b_dir, b_rd;
  logic            hit_a_dat, hit_a_dir, hit_b_dat, hit_b_dir;

  assign hit_a_dat = bus_we && (bus_addr == A_DAT);
  assign hit_a_dir = bus_we && (bus_addr == A_DIR);
  assign hit_b_dat = bus_we && (bus_addr == B_DAT);
  assign hit_b_dir = bus_we && (bus_addr == B_DIR);

  gpio_port_bank #(.W(PA_W)) u_port_a (
    .clk(clk), .rst_n(rst_n), .wr_data(hit_a_dat), .wr_dir(hit_a_dir),
    .wdata(bus_wdata[PA_W-1:0]), .pad_in(pa_in),
    .latch_q(a_latch), .dir_q(a_dir), .rd_data(a_rd));

  gpio_port_bank #(.W(PB_W)) u_port_b (
    .clk(clk), .rst_n(rst_n), .wr_data(hit_b_dat), .wr_dir(hit_b_dir),
    .wdata(bus_wdata[PB_W-1:0]), .pad_in(pb_in),
    .latch_q(b_latch), .dir_q(b_dir), .rd_data(b_rd));

  gpio_wake_detect #(.W(PA_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .halt(halt),
    .pad_in(pa_in), .wake_en(wake_en_a), .in_mode(a_dir), .wake(wake));

  assign pa_out = a_latch;
  assign pa_oe  = ~a_dir;
  assign pa_pu  = a_dir & {PA_W{pu_opt_a}};
  assign pb_out = b_latch;
  assign pb_oe  = ~b_dir;
  assign pb_pu  = b_dir & {PB_W{pu_opt_b}};

  always_comb begin
    case (bus_addr)
      A_DAT:   bus_rdata = DATA_W'(a_rd);
      A_DIR:   bus_rdata = DATA_W'(a_dir);
      B_DAT:   bus_rdata = DATA_W'(b_rd);
      B_DIR:   bus_rdata = DATA_W'(b_dir);
      default: bus_rdata = '0;
    endcase
  end

  assert_pb_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == B_DAT || bus_addr == B_DIR) |-> bus_rdata[DATA_W-1:PB_W] == '0);
  assert_out_bits_read_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DAT) |-> ((bus_rdata[PA_W-1:0] ^ pa_out) & pa_oe) == '0);
  assert_dir_vs_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DIR) |-> bus_rdata[PA_W-1:0] == ~pa_oe);
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < A_DAT || bus_addr > B_DIR) |-> bus_rdata == '0);
endmodule

// File: tb/gpio_wake_port_tb.sv
module gpio_wake_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       warm_rst = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'hFF;
  logic [7:0] pa_out, pa_oe, pa_pu;
  logic [2:0] pb_in = 3'b111;
  logic [2:0] pb_out, pb_oe, pb_pu;
  logic       pu_opt_a = 1'b1;
  logic       pu_opt_b = 1'b0;
  logic [7:0] wake_en_a = 8'h05;
  logic       halt = 1'b0;
  logic       wake;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  // observed-signal selectors for the scoreboard
  localparam int K_RD = 0, K_AOE = 1, K_AOUT = 2, K_BOE = 3, K_BOUT = 4,
                 K_APU = 5, K_BPU = 6, K_WAKE = 7;

  int         q_kind[$];
  logic [7:0] q_val[$];
  string      q_req[$];
  event       sample_ev;

  always #5 clk = ~clk;

  gpio_wake_port u_dut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_pu(pa_pu),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_pu(pb_pu),
    .pu_opt_a(pu_opt_a), .pu_opt_b(pu_opt_b), .wake_en_a(wake_en_a),
    .halt(halt), .wake(wake));

  // monitor: drains the expected queue and compares against the ports
  always @(sample_ev) begin
    while (q_kind.size() > 0) begin
      int         k;
      logic [7:0] e, a;
      string      r;
      k = q_kind.pop_front();
      e = q_val.pop_front();
      r = q_req.pop_front();
      case (k)
        K_RD:    a = bus_rdata;
        K_AOE:   a = pa_oe;
        K_AOUT:  a = pa_out;
        K_BOE:   a = {5'b0, pb_oe};
        K_BOUT:  a = {5'b0, pb_out};
        K_APU:   a = pa_pu;
        K_BPU:   a = {5'b0, pb_pu};
        default: a = {7'b0, wake};
      endcase
      nchk++;
      if (a !== e) begin
        nbad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", r, k, a, e);
      end
    end
  end

  task automatic push_sample(int k, logic [7:0] v, string r);
    q_kind.push_back(k);
    q_val.push_back(v);
    q_req.push_back(r);
    #1;
    -> sample_ev;
    #0;
  endtask

  task automatic chk_reg(logic [7:0] a, logic [7:0] v, string r);
    @(negedge clk);
    bus_addr = a;
    push_sample(K_RD, v, r);
  endtask

  task automatic chk_sig(int k, logic [7:0] v, string r);
    @(negedge clk);
    push_sample(k, v, r);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // five cycles of wake observation; hit_at = 0 means no pulse expected
  task automatic wake_window(int hit_at, string r);
    for (int i = 1; i <= 5; i++)
      chk_sig(K_WAKE, (i == hit_at) ? 8'h01 : 8'h00, r);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R2 reset state
    chk_reg(8'h13, 8'hFF, "R2 A dir");
    chk_reg(8'h15, 8'h07, "R2 B dir");
    chk_sig(K_AOE, 8'h00, "R2 A oe");
    chk_sig(K_AOUT, 8'hFF, "R2 A out");
    chk_sig(K_BOE, 8'h00, "R2 B oe");
    chk_sig(K_BOUT, 8'h07, "R2 B out");
    chk_reg(8'h12, 8'hFF, "R4 A data pads");

    // R1 map: unmapped reads and writes
    chk_reg(8'h10, 8'h00, "R1 unmapped read");
    wr(8'h16, 8'h55);
    chk_reg(8'h13, 8'hFF, "R1 A dir after stray write");
    chk_reg(8'h15, 8'h07, "R1 B dir after stray write");
    chk_sig(K_AOUT, 8'hFF, "R1 A out after stray write");

    // R3/R4 mixed directions: upper nibble output
    wr(8'h13, 8'h0F);
    wr(8'h12, 8'hA5);
    chk_sig(K_AOE, 8'hF0, "R3 A oe");
    chk_sig(K_AOUT, 8'hA5, "R3 A out");
    pa_in = 8'h3C;
    chk_reg(8'h12, {4'hA, 4'hC}, "R4 mixed read");

    // R5 latch holds; write while input
    pa_in = 8'h00;
    chk_reg(8'h12, {4'hA, 4'h0}, "R5 latch kept");
    wr(8'h12, 8'h3C);
    wr(8'h13, 8'h00);
    chk_sig(K_AOUT, 8'h3C, "R5 out after dir change");
    chk_reg(8'h12, 8'h3C, "R5 latch read");

    // R6 port B narrow
    wr(8'h14, 8'hFF);
    wr(8'h15, 8'hF8);
    chk_reg(8'h15, 8'h00, "R6 B dir upper dropped");
    chk_sig(K_BOE, 8'h07, "R6 B oe");
    chk_reg(8'h14, 8'h07, "R6 B data upper zero");
    wr(8'h15, 8'hFA);
    chk_reg(8'h15, 8'h02, "R6 B dir readback");
    pb_in = 3'b000;
    chk_reg(8'h14, 8'h05, "R6 B mixed read");

    // R10 pull-up requests
    chk_sig(K_APU, 8'h00, "R10 A pu all out");
    wr(8'h13, 8'hF0);
    chk_sig(K_APU, 8'hF0, "R10 A pu");
    chk_sig(K_BPU, 8'h00, "R10 B pu option off");

    // R7 warm reset keeps registers
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    chk_reg(8'h13, 8'hF0, "R7 A dir kept");
    chk_reg(8'h15, 8'h02, "R7 B dir kept");
    chk_sig(K_AOUT, 8'h3C, "R7 A out kept");
    chk_sig(K_BOUT, 8'h07, "R7 B out kept");

    // R8 wake on enabled input bit 0
    wr(8'h13, 8'hFF);
    pa_in = 8'hFF;
    idle(5);
    halt = 1'b1;
    @(negedge clk); pa_in = 8'hFE;
    wake_window(3, "R8 wake bit0");

    // R9 rising edge: none
    @(negedge clk); pa_in = 8'hFF;
    wake_window(0, "R9 rising edge");
    // R9 option clear on bit 1
    @(negedge clk); pa_in = 8'hFD;
    wake_window(0, "R9 option clear");
    @(negedge clk); pa_in = 8'hFF;
    idle(4);
    // R9 enabled bit 2 set as output
    wr(8'h13, 8'hFB);
    @(negedge clk); pa_in = 8'hFB;
    wake_window(0, "R9 bit is output");
    @(negedge clk); pa_in = 8'hFF;
    idle(4);
    // R9 halt low
    wr(8'h13, 8'hFF);
    halt = 1'b0;
    @(negedge clk); pa_in = 8'hFE;
    wake_window(0, "R9 not halted");
    @(negedge clk); pa_in = 8'hFF;
    idle(4);
    // R8 again on bit 2 once it is an input
    halt = 1'b1;
    @(negedge clk); pa_in = 8'hFB;
    wake_window(3, "R8 wake bit2");

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule